// File: doc/BRIEF.md
# Machine-Mode Control Register and Trap Unit

This block holds the small set of machine-mode control and status registers that a compact 32-bit integer core needs, and it decides, cycle by cycle, whether the pipeline takes a trap, returns from one, or performs a register access. The execute stage presents at most one register request (address, operation, write data). In the same cycle it may also present an exception request (kind, instruction PC, faulting address), a trap-return request and a wait-for-interrupt request. The block answers combinationally with the read data, an illegal-access flag, a trap-taken flag and a fetch redirect. The register updates land on the next rising clock edge.

Each cycle falls into one of four event classes, named by an enumerated type: EV_IDLE (nothing to do, which includes a lone wait-for-interrupt), EV_TRAP (a valid exception kind), EV_RETURN (trap return) and EV_ACCESS (a register request). The class is picked in fixed priority order: EV_TRAP over EV_RETURN, EV_RETURN over EV_ACCESS, and EV_ACCESS over EV_IDLE. The transitions of the saved-state registers are TRAP (the PC, cause and bad address are captured, the enable is pushed into the saved enable) and RETURN (the saved enable is popped back). An access event writes a single register. Each register has its own fixed access rule. The vector register is write-only, the ISA register reads zero, the cause and bad-address registers are read-only, and the cycle and retired-instruction counters are absent.

Top module: `csr_trap_unit`

## Requirements
- R1: After reset, reads return 0x00001800 at 0x300 and zero at 0x301, 0x304, 0x305, 0x340, 0x341, 0x342 and 0x343.
- R2: csr_op encodes 00 read, 01 write, 10 set bits, 11 clear bits. csr_rdata shows the value before the write in the same cycle, and the new value is visible from the next cycle. Without csr_valid, csr_rdata and csr_illegal are zero.
- R3: Address 0x301 always reads zero, accepts every operation without raising csr_illegal, and ignores writes.
- R4: Address 0x305 stores write bits 31:2 and always reads zero. A trap redirects to the stored bits 31:2 with bits 1:0 zero.
- R5: Address 0x340 keeps all 32 bits. Address 0x341 keeps bits 31:2 and reads bits 1:0 as zero.
- R6: At 0x342 and 0x343, any operation other than read raises csr_illegal and changes nothing. Reads return the trap-captured values.
- R7: Any other address, including the counter addresses 0xC00, 0xC02, 0xB00 and 0xB02, raises csr_illegal, reads zero and changes no state.
- R8: At 0x300, bit 3 (enable) and bit 7 (saved enable) are writable and bits 12:11 read 11. At 0x304 only bits 3, 7 and 11 are writable.
- R9: exc_kind encodes 0 environment call, 1 breakpoint, 2 misaligned branch target, 3 misaligned load, 4 misaligned store. A valid kind raises trap_taken and redirect_valid in the same cycle. From the next cycle, the cause register holds 11, 3, 0, 4 or 6 respectively, 0x341 holds exc_pc with bits 1:0 cleared, and 0x343 holds exc_addr for kinds 2 to 4 and zero for kinds 0 and 1. Kinds 5 to 7 have no effect.
- R10: A trap copies bit 3 of 0x300 into bit 7 and clears bit 3.
- R11: ret_valid raises redirect_valid (without trap_taken) with redirect_pc equal to the value of 0x341. Next cycle, bit 3 takes the old bit 7, and bit 7 is set.
- R12: Priority is trap over return over register access. A lower-priority write is dropped, yet csr_rdata and csr_illegal are still reported. redirect_pc is zero when redirect_valid is low.
- R13: wfi_valid causes no redirect and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_valid | input | 1 | Register request present |
| csr_addr | input | 12 | Register address |
| csr_op | input | 2 | Operation: read, write, set, clear |
| csr_wdata | input | 32 | Write operand |
| exc_valid | input | 1 | Exception request present |
| exc_kind | input | 3 | Exception kind |
| exc_pc | input | 32 | PC of faulting instruction |
| exc_addr | input | 32 | Faulting address, if any |
| ret_valid | input | 1 | Trap-return instruction |
| wfi_valid | input | 1 | Wait-for-interrupt instruction |
| csr_rdata | output | 32 | Read data for the request |
| csr_illegal | output | 1 | Request is not permitted |
| trap_taken | output | 1 | Trap taken this cycle |
| redirect_valid | output | 1 | Fetch must redirect |
| redirect_pc | output | 32 | Redirect target |

## Verification
The assertions assume that every request input is a known value whenever its valid is high, and that the request inputs stay stable across a rising edge, so that the event class sampled at an edge matches the one that drove the outputs. The bench changes inputs only at falling edges and holds all of them at defined values from reset onward. Its random phase draws addresses from a pool of mapped and unmapped addresses and mixes in exception kinds, including the reserved ones, plus trap returns and wait-for-interrupt. This drives every event class and every collision between them.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic [2:0] {
        EXC_ECALL  = 3'd0,
        EXC_EBREAK = 3'd1,
        EXC_BRANCH = 3'd2,
        EXC_LOAD   = 3'd3,
        EXC_STORE  = 3'd4
    } exc_kind_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ISA,
        SEL_IE,
        SEL_VEC,
        SEL_SCRATCH,
        SEL_EPC,
        SEL_CAUSE,
        SEL_BADADDR
    } csr_sel_e;

    typedef enum logic [1:0] {
        EV_IDLE,
        EV_TRAP,
        EV_RETURN,
        EV_ACCESS
    } event_e;

    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] A_STATUS  = 12'h300;
    localparam logic [ADDR_W-1:0] A_ISA     = 12'h301;
    localparam logic [ADDR_W-1:0] A_IE      = 12'h304;
    localparam logic [ADDR_W-1:0] A_VEC     = 12'h305;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 12'h340;
    localparam logic [ADDR_W-1:0] A_EPC     = 12'h341;
    localparam logic [ADDR_W-1:0] A_CAUSE   = 12'h342;
    localparam logic [ADDR_W-1:0] A_BADADDR = 12'h343;

    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CODE_MISALIGN_FETCH = 5'd0;
    localparam logic [CAUSE_W-1:0] CODE_BREAK          = 5'd3;
    localparam logic [CAUSE_W-1:0] CODE_MISALIGN_LOAD  = 5'd4;
    localparam logic [CAUSE_W-1:0] CODE_MISALIGN_STORE = 5'd6;
    localparam logic [CAUSE_W-1:0] CODE_ENV_CALL       = 5'd11;

    localparam int BIT_IE      = 3;
    localparam int BIT_PIE     = 7;
    localparam int BIT_PRIV_LO = 11;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_trap_pkg::*;
(
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_op,
    output csr_sel_e          sel,
    output logic              illegal
);

    logic read_only;

    always_comb begin
        unique case (req_addr)
            A_STATUS:  sel = SEL_STATUS;
            A_ISA:     sel = SEL_ISA;
            A_IE:      sel = SEL_IE;
            A_VEC:     sel = SEL_VEC;
            A_SCRATCH: sel = SEL_SCRATCH;
            A_EPC:     sel = SEL_EPC;
            A_CAUSE:   sel = SEL_CAUSE;
            A_BADADDR: sel = SEL_BADADDR;
            default:   sel = SEL_NONE;
        endcase
    end

    assign read_only = (sel == SEL_CAUSE) || (sel == SEL_BADADDR);

    always_comb begin
        illegal = 1'b0;
        if (req_valid) begin
            if (sel == SEL_NONE)
                illegal = 1'b1;
            else if (read_only && (req_op != OP_READ))
                illegal = 1'b1;
        end
    end

endmodule

// File: rtl/csr_event_ctl.sv
module csr_event_ctl
    import csr_trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               exc_valid,
    input  logic [2:0]         exc_kind,
    input  logic [XLEN-1:0]    exc_pc,
    input  logic [XLEN-1:0]    exc_addr,
    input  logic               ret_valid,
    input  logic               wfi_valid,
    input  logic               csr_valid,
    output event_e             ev,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [XLEN-1:0]    trap_badaddr,
    output logic [XLEN-1:0]    trap_epc
);

    localparam logic [XLEN-1:0] PC_MASK = ~(XLEN'(3));

    logic kind_known;

    always_comb begin
        kind_known   = 1'b1;
        trap_cause   = CODE_MISALIGN_FETCH;
        trap_badaddr = '0;
        unique case (exc_kind)
            EXC_ECALL:  trap_cause = CODE_ENV_CALL;
            EXC_EBREAK: trap_cause = CODE_BREAK;
            EXC_BRANCH: begin
                trap_cause   = CODE_MISALIGN_FETCH;
                trap_badaddr = exc_addr;
            end
            EXC_LOAD: begin
                trap_cause   = CODE_MISALIGN_LOAD;
                trap_badaddr = exc_addr;
            end
            EXC_STORE: begin
                trap_cause   = CODE_MISALIGN_STORE;
                trap_badaddr = exc_addr;
            end
            default: kind_known = 1'b0;
        endcase
    end

    assign trap_epc = exc_pc & PC_MASK;

    // Fixed-priority event classification; wait-for-interrupt is an idle cycle
    always_comb begin
        if (exc_valid && kind_known)
            ev = EV_TRAP;
        else if (ret_valid)
            ev = EV_RETURN;
        else if (csr_valid)
            ev = EV_ACCESS;
        else if (wfi_valid)
            ev = EV_IDLE;
        else
            ev = EV_IDLE;
    end

endmodule

// File: rtl/csr_state_regs.sv
module csr_state_regs
    import csr_trap_pkg::*;
#(
    parameter int XLEN = 32,
    parameter logic [XLEN-1:0] VEC_RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  event_e             ev,
    input  csr_sel_e           sel,
    input  logic [1:0]         op,
    input  logic [XLEN-1:0]    wdata,
    input  logic               illegal,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_badaddr,
    input  logic [XLEN-1:0]    trap_epc,
    output logic [XLEN-1:0]    rd_value,
    output logic [XLEN-1:0]    vec_target,
    output logic [XLEN-1:0]    ret_target
);

    localparam logic [XLEN-1:0] IE_MASK =
        (XLEN'(1) << 3) | (XLEN'(1) << 7) | (XLEN'(1) << 11);
    localparam logic [XLEN-1:0] PC_MASK = ~(XLEN'(3));

    logic                  st_ie_q;
    logic                  st_pie_q;
    logic [XLEN-1:0]       ie_en_q;
    logic [XLEN-1:2]       vec_base_q;
    logic [XLEN-1:0]       scratch_q;
    logic [XLEN-1:0]       epc_q;
    logic [CAUSE_W-1:0]    cause_q;
    logic [XLEN-1:0]       badaddr_q;

    logic [XLEN-1:0]       status_view;
    logic [XLEN-1:0]       old_raw;
    logic [XLEN-1:0]       new_val;
    logic                  wr_en;

    always_comb begin
        status_view = '0;
        status_view[BIT_IE] = st_ie_q;
        status_view[BIT_PIE] = st_pie_q;
        status_view[BIT_PRIV_LO +: 2] = 2'b11;
    end

    // Software-visible value and raw stored value per register
    always_comb begin
        rd_value = '0;
        old_raw  = '0;
        unique case (sel)
            SEL_STATUS:  begin rd_value = status_view; old_raw = status_view; end
            SEL_ISA:     begin rd_value = '0;          old_raw = '0;          end
            SEL_IE:      begin rd_value = ie_en_q;     old_raw = ie_en_q;     end
            SEL_VEC:     begin rd_value = '0;          old_raw = {vec_base_q, 2'b00}; end
            SEL_SCRATCH: begin rd_value = scratch_q;   old_raw = scratch_q;   end
            SEL_EPC:     begin rd_value = epc_q;       old_raw = epc_q;       end
            SEL_CAUSE:   begin rd_value = XLEN'(cause_q); old_raw = XLEN'(cause_q); end
            SEL_BADADDR: begin rd_value = badaddr_q;   old_raw = badaddr_q;   end
            default:     begin rd_value = '0;          old_raw = '0;          end
        endcase
    end

    always_comb begin
        unique case (op)
            OP_WRITE: new_val = wdata;
            OP_SET:   new_val = old_raw | wdata;
            OP_CLEAR: new_val = old_raw & ~wdata;
            default:  new_val = old_raw;
        endcase
    end

    assign wr_en = (ev == EV_ACCESS) && !illegal && (op != OP_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_ie_q    <= 1'b0;
            st_pie_q   <= 1'b0;
            ie_en_q    <= '0;
            vec_base_q <= VEC_RESET[XLEN-1:2];
            scratch_q  <= '0;
            epc_q      <= '0;
            cause_q    <= '0;
            badaddr_q  <= '0;
        end else begin
            unique case (ev)
                EV_TRAP: begin
                    epc_q     <= trap_epc;
                    cause_q   <= trap_cause;
                    badaddr_q <= trap_badaddr;
                    st_pie_q  <= st_ie_q;
                    st_ie_q   <= 1'b0;
                end
                EV_RETURN: begin
                    st_ie_q  <= st_pie_q;
                    st_pie_q <= 1'b1;
                end
                EV_ACCESS: begin
                    if (wr_en) begin
                        unique case (sel)
                            SEL_STATUS: begin
                                st_ie_q  <= new_val[BIT_IE];
                                st_pie_q <= new_val[BIT_PIE];
                            end
                            SEL_IE:      ie_en_q    <= new_val & IE_MASK;
                            SEL_VEC:     vec_base_q <= new_val[XLEN-1:2];
                            SEL_SCRATCH: scratch_q  <= new_val;
                            SEL_EPC:     epc_q      <= new_val & PC_MASK;
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    assign vec_target = {vec_base_q, 2'b00};
    assign ret_target = epc_q;

    // R10: trap pushes the enable into the saved enable and clears it
    a_r10_trap_push: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TRAP) |=> (!st_ie_q && (st_pie_q == $past(st_ie_q))));

    // R11: return pops the saved enable and sets the saved enable
    a_r11_return_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_RETURN) |=> (st_pie_q && (st_ie_q == $past(st_pie_q))));

    // R6: software access never alters the cause or bad-address registers
    a_r6_cause_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ACCESS) |=> ($stable(cause_q) && $stable(badaddr_q)));

    // R9: captured PC of the faulting instruction
    a_r9_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TRAP) |=> (epc_q == ($past(trap_epc))));

    // R5: exception PC is always word aligned
    a_r5_epc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        epc_q[1:0] == 2'b00);

endmodule

// File: rtl/csr_trap_unit.sv
module csr_trap_unit
    import csr_trap_pkg::*;
#(
    parameter int XLEN = 32,
    parameter logic [XLEN-1:0] VEC_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_valid,
    input  logic [11:0]       csr_addr,
    input  logic [1:0]        csr_op,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic              exc_valid,
    input  logic [2:0]        exc_kind,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic [XLEN-1:0]   exc_addr,
    input  logic              ret_valid,
    input  logic              wfi_valid,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    output logic              trap_taken,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc
);

    csr_sel_e           sel;
    event_e             ev;
    logic [CAUSE_W-1:0] trap_cause;
    logic [XLEN-1:0]    trap_badaddr;
    logic [XLEN-1:0]    trap_epc;
    logic [XLEN-1:0]    rd_value;
    logic [XLEN-1:0]    vec_target;
    logic [XLEN-1:0]    ret_target;

    csr_addr_decode u_decode (
        .req_valid (csr_valid),
        .req_addr  (csr_addr),
        .req_op    (csr_op),
        .sel       (sel),
        .illegal   (csr_illegal)
    );

    csr_event_ctl #(.XLEN(XLEN)) u_event (
        .exc_valid    (exc_valid),
        .exc_kind     (exc_kind),
        .exc_pc       (exc_pc),
        .exc_addr     (exc_addr),
        .ret_valid    (ret_valid),
        .wfi_valid    (wfi_valid),
        .csr_valid    (csr_valid),
        .ev           (ev),
        .trap_cause   (trap_cause),
        .trap_badaddr (trap_badaddr),
        .trap_epc     (trap_epc)
    );

    csr_state_regs #(.XLEN(XLEN), .VEC_RESET(VEC_RESET)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .sel          (sel),
        .op           (csr_op),
        .wdata        (csr_wdata),
        .illegal      (csr_illegal),
        .trap_cause   (trap_cause),
        .trap_badaddr (trap_badaddr),
        .trap_epc     (trap_epc),
        .rd_value     (rd_value),
        .vec_target   (vec_target),
        .ret_target   (ret_target)
    );

    assign csr_rdata = csr_valid ? rd_value : '0;

    always_comb begin
        trap_taken     = 1'b0;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        unique case (ev)
            EV_TRAP: begin
                trap_taken     = 1'b1;
                redirect_valid = 1'b1;
                redirect_pc    = vec_target;
            end
            EV_RETURN: begin
                redirect_valid = 1'b1;
                redirect_pc    = ret_target;
            end
            default: ;
        endcase
    end

    // R9: a trap always redirects to a word-aligned vector
    a_r9_trap_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (redirect_valid && (redirect_pc[1:0] == 2'b00)));

    // R7: an unmapped address is flagged and returns zero
    a_r7_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && (sel == SEL_NONE)) |-> (csr_illegal && (csr_rdata == '0)));

    // R12: no redirect target without a redirect
    a_r12_quiet_target: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |-> (redirect_pc == '0));

    // R13: a lone wait-for-interrupt never redirects
    a_r13_wfi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wfi_valid && !exc_valid && !ret_valid) |-> !redirect_valid);

endmodule

// File: tb/csr_trap_unit_test.sv
module csr_trap_unit_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_wdata = '0;
    logic        exc_valid = 1'b0;
    logic [2:0]  exc_kind = '0;
    logic [31:0] exc_pc = '0;
    logic [31:0] exc_addr = '0;
    logic        ret_valid = 1'b0;
    logic        wfi_valid = 1'b0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic        trap_taken;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    csr_trap_unit uut (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .exc_valid(exc_valid),
        .exc_kind(exc_kind), .exc_pc(exc_pc), .exc_addr(exc_addr),
        .ret_valid(ret_valid), .wfi_valid(wfi_valid), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .trap_taken(trap_taken),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    always #(PERIOD/2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    // Reference model state
    bit        m_ie, m_pie;
    bit [31:0] m_ien, m_vec, m_scr, m_epc, m_cause, m_bad;

    function automatic bit m_mapped(input bit [11:0] a);
        return a inside {12'h300, 12'h301, 12'h304, 12'h305,
                         12'h340, 12'h341, 12'h342, 12'h343};
    endfunction

    function automatic bit [31:0] m_view(input bit [11:0] a);
        case (a)
            12'h300: return (32'(m_ie) << 3) | (32'(m_pie) << 7) | 32'h1800;
            12'h304: return m_ien;
            12'h340: return m_scr;
            12'h341: return m_epc;
            12'h342: return m_cause;
            12'h343: return m_bad;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit [31:0] m_stored(input bit [11:0] a);
        if (a == 12'h305) return m_vec;
        return m_view(a);
    endfunction

    task automatic chk(input string what, input bit [31:0] act, input bit [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit cv, input bit [11:0] ca, input bit [1:0] co,
                       input bit [31:0] cw, input bit ev, input bit [2:0] ek,
                       input bit [31:0] ep, input bit [31:0] ea,
                       input bit rv, input bit wf);
        bit trap, ret, acc, ill;
        bit [31:0] e_rd, e_pc, old, nv;
        int code;
        csr_valid = cv; csr_addr = ca; csr_op = co; csr_wdata = cw;
        exc_valid = ev; exc_kind = ek; exc_pc = ep; exc_addr = ea;
        ret_valid = rv; wfi_valid = wf;
        #1;
        trap = ev && (ek <= 3'd4);
        ret  = !trap && rv;
        acc  = !trap && !ret && cv;
        ill  = cv && (!m_mapped(ca) || (co != 2'b00 && (ca == 12'h342 || ca == 12'h343)));
        e_rd = cv ? m_view(ca) : 32'h0;
        e_pc = trap ? {m_vec[31:2], 2'b00} : (ret ? m_epc : 32'h0);
        chk("csr_rdata", csr_rdata, e_rd);
        chk("csr_illegal", 32'(csr_illegal), 32'(ill));
        chk("trap_taken", 32'(trap_taken), 32'(trap));
        chk("redirect_valid", 32'(redirect_valid), 32'(trap || ret));
        chk("redirect_pc", redirect_pc, e_pc);
        @(posedge clk);
        if (trap) begin
            case (ek)
                3'd0: code = 11;
                3'd1: code = 3;
                3'd2: code = 0;
                3'd3: code = 4;
                default: code = 6;
            endcase
            m_epc = ep & ~32'h3;
            m_cause = 32'(code);
            m_bad = (ek >= 3'd2) ? ea : 32'h0;
            m_pie = m_ie;
            m_ie = 1'b0;
        end else if (ret) begin
            m_ie = m_pie;
            m_pie = 1'b1;
        end else if (acc && !ill && co != 2'b00) begin
            old = m_stored(ca);
            case (co)
                2'b01: nv = cw;
                2'b10: nv = old | cw;
                default: nv = old & ~cw;
            endcase
            case (ca)
                12'h300: begin m_ie = nv[3]; m_pie = nv[7]; end
                12'h304: m_ien = nv & 32'h888;
                12'h305: m_vec = nv & ~32'h3;
                12'h340: m_scr = nv;
                12'h341: m_epc = nv & ~32'h3;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic rd(input bit [11:0] a);
        cyc(1, a, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wr(input bit [11:0] a, input bit [1:0] o, input bit [31:0] d);
        cyc(1, a, o, d, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic exc(input bit [2:0] k, input bit [31:0] pc, input bit [31:0] ad);
        cyc(0, 0, 0, 0, 1, k, pc, ad, 0, 0);
    endtask
    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic read_all();
        rd(12'h300); rd(12'h301); rd(12'h304); rd(12'h305);
        rd(12'h340); rd(12'h341); rd(12'h342); rd(12'h343);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired (run did not complete)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit [11:0] pool [12] = '{12'h300, 12'h301, 12'h304, 12'h305, 12'h340, 12'h341,
                                 12'h342, 12'h343, 12'hC00, 12'hC02, 12'hB00, 12'h7C0};
        m_ie = 0; m_pie = 0; m_ien = 0; m_vec = 0; m_scr = 0;
        m_epc = 0; m_cause = 0; m_bad = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_tag = "R1"; read_all(); idle();

        cur_tag = "R3"; wr(12'h301, 2'b01, 32'hFFFF_FFFF); rd(12'h301);
        wr(12'h301, 2'b10, 32'h0000_0104); rd(12'h301);

        cur_tag = "R4"; wr(12'h305, 2'b01, 32'h8000_0103); rd(12'h305);
        wr(12'h305, 2'b10, 32'h0000_0010);

        cur_tag = "R5"; wr(12'h340, 2'b01, 32'hDEAD_BEEF); rd(12'h340);
        wr(12'h340, 2'b10, 32'h0000_0F00); wr(12'h340, 2'b11, 32'hFF00_0000);
        rd(12'h340); wr(12'h341, 2'b01, 32'h0000_1237); rd(12'h341);

        cur_tag = "R8"; wr(12'h300, 2'b01, 32'hFFFF_FFFF); rd(12'h300);
        wr(12'h300, 2'b11, 32'h0000_0080); rd(12'h300);
        wr(12'h304, 2'b01, 32'hFFFF_FFFF); rd(12'h304);
        wr(12'h304, 2'b11, 32'h0000_0080); rd(12'h304);

        cur_tag = "R6"; wr(12'h342, 2'b01, 32'h1234_5678); wr(12'h343, 2'b10, 32'hFFFF_FFFF);
        wr(12'h342, 2'b11, 32'hFFFF_FFFF); rd(12'h342); rd(12'h343);

        cur_tag = "R7"; rd(12'hC00); rd(12'hC02); rd(12'hB00); rd(12'hB02);
        wr(12'h7C0, 2'b01, 32'h5555_5555); read_all();

        for (int k = 0; k < 8; k++) begin
            cur_tag = "R10"; wr(12'h300, 2'b10, 32'h0000_0008);
            cur_tag = "R9";
            exc(3'(k), 32'h0000_4000 + 32'(k * 16) + 32'(k % 4), 32'hA000_0001 + 32'(k));
            rd(12'h342); rd(12'h341); rd(12'h343);
            cur_tag = "R10"; rd(12'h300);
            cur_tag = "R11"; cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0); rd(12'h300);
        end

        cur_tag = "R12";
        cyc(1, 12'h340, 2'b01, 32'h1111_1111, 1, 3'd3, 32'h2000, 32'h77, 1, 0);
        rd(12'h340); rd(12'h300);
        cyc(1, 12'h340, 2'b01, 32'h2222_2222, 0, 0, 0, 0, 1, 0);
        rd(12'h340);
        cyc(1, 12'hC00, 2'b01, 32'h3, 0, 0, 0, 0, 1, 0);
        cyc(1, 12'h342, 2'b01, 32'h3, 1, 3'd6, 32'h10, 32'h20, 0, 0);
        rd(12'h342);

        cur_tag = "R13";
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        cyc(1, 12'h340, 2'b00, 32'h0, 0, 0, 0, 0, 0, 1);
        read_all();

        cur_tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            bit [11:0] a = pool[$urandom_range(0, 11)];
            cyc($urandom_range(0, 3) != 0, a, 2'($urandom), $urandom,
                r < 8, 3'($urandom), $urandom, $urandom,
                (r >= 8 && r < 14) || r == 99, r >= 90);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule